// File: doc/BRIEF.md
# Framed Serial Word Transceiver

This block is the shifting core of a synchronous serial port for codecs and converters. A parallel word written into a transmit holding register is sent MSB first on a serial data line, one bit per bit-clock period. On the receive side, serial bits are collected into a word that is handed over through a receive data register. The bit clocks and frame syncs arrive as level inputs. The block samples them with its own system clock and works from the edges it detects.

Each direction can be framed in one of two ways. In the first, the frame sync is high for the whole word. In the second, the frame sync is high for a single bit period just before the word. A shared length bit chooses the style, and a second bit can give the transmitter the opposite style from the receiver. In gated-clock mode there is no frame sync: each burst of clock pulses is one word. The receiver can either follow the transmit clock and frame sync, or run from a clock and frame sync of its own.

Top module: `fsx_xcvr`

## Requirements
- R1: Word length follows `cfg_wl`: 0 gives 8 bits, 1 gives 12, 2 gives 16 and 3 gives 24. Both directions use the low W bits of their data registers.
- R2: With word-length framing, a transmit word starts at a bit-clock rising edge that finds frame sync high while no word is in progress. The MSB is driven in that same bit period, and each later bit is driven on the next rising edge.
- R3: With one-bit framing, a rising edge that finds frame sync high arms the side. The MSB is driven from the following rising edge, and `tx_oe` stays low during the sync bit itself.
- R4: `cfg_fs_bit` gives the receiver its style (1 = one-bit, 0 = word-length). The transmitter uses the same style when `cfg_fs_diff` is 0 and the opposite style when it is 1.
- R5: Receive bits are sampled on bit-clock falling edges, MSB first. After the W-th sample, `rx_data` holds the word right-justified with zeros above, and `rx_full` goes high.
- R6: A frame sync seen while a word is in progress, before its last bit, is ignored. A one-bit sync pulse that arrives mid-word neither restarts the word nor starts a new one.
- R7: `tx_oe` is high only while a word is being sent, and `tx_sd` is 0 whenever `tx_oe` is low. In continuous-clock mode, `tx_oe` stays high through the last bit and drops at the next rising edge unless a new word starts there.
- R8: In gated-clock mode the frame sync inputs are ignored. The first rising edge while idle starts a word, and `tx_oe` drops at the falling edge of the last bit.
- R9: With `cfg_sync`=1 the receiver uses `tx_sck` and `tx_fs`, and `rx_sck` and `rx_fs` have no effect. With `cfg_sync`=0 the receiver uses only `rx_sck` and `rx_fs`.
- R10: `tx_load` writes the holding register and clears `tx_empty`. `tx_empty` rises when a word moves into the shifter. If a load and a move fall in the same cycle, the shifter takes the old word and `tx_empty` ends low.
- R11: `rx_ack` clears `rx_full`. If an acknowledge falls in the same cycle as a word completion, `rx_full` stays high.
- R12: `cfg_err` is high, one cycle after the configuration is applied, exactly when the clock is continuous (`cfg_gated`=0), `cfg_single_word`=1, and either direction uses word-length framing.
- R13: Words can follow each other with no idle bit in either framing style. `tx_oe` stays high across the boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wl | input | 2 | Word length select |
| cfg_fs_bit | input | 1 | Receiver framing: 1 one-bit early, 0 word-length |
| cfg_fs_diff | input | 1 | Transmitter uses the opposite framing |
| cfg_gated | input | 1 | Gated-clock mode, no frame sync |
| cfg_sync | input | 1 | Receiver shares the transmit clock and frame sync |
| cfg_single_word | input | 1 | Frames are one word long |
| tx_sck | input | 1 | Transmit (or shared) bit clock |
| tx_fs | input | 1 | Transmit (or shared) frame sync |
| rx_sck | input | 1 | Receive bit clock in separate-clock mode |
| rx_fs | input | 1 | Receive frame sync in separate-clock mode |
| rx_sd | input | 1 | Serial receive data |
| tx_data | input | MAX_W | Word to transmit |
| tx_load | input | 1 | Write `tx_data` into the holding register |
| rx_ack | input | 1 | Acknowledge the received word |
| tx_sd | output | 1 | Serial transmit data |
| tx_oe | output | 1 | Output enable for `tx_sd` |
| tx_empty | output | 1 | Holding register free |
| rx_data | output | MAX_W | Received word |
| rx_full | output | 1 | Received word waiting |
| cfg_err | output | 1 | Unsupported framing combination |

## Verification
Two events can land in the same cycle. A word moves from the holding register into the shifter at the system-clock cycle that handles a bit-clock rising edge, and software can write the holding register in that same cycle. The bench places `tx_load` on exactly that cycle, counted from the sampled clock edge. It then expects the current frame to carry the old word, `tx_empty` to stay low, and the following back-to-back frame to carry the new word. The receive side has the same kind of collision: an acknowledge is placed on the cycle that completes a word, and `rx_full` must stay high until a later acknowledge clears it.

// File: rtl/fsx_pkg.sv
package fsx_pkg;
  // Encoded word-length select to bit count.
  function automatic int unsigned word_bits(input logic [1:0] sel);
    case (sel)
      2'd0:    return 8;
      2'd1:    return 12;
      2'd2:    return 16;
      default: return 24;
    endcase
  endfunction
endpackage

// File: rtl/fsx_edge.sv
// Samples a bit clock and its frame sync into the system clock domain and
// produces single-cycle edge strobes aligned with the sampled sync level.
module fsx_edge (
  input  logic clk,
  input  logic rst,
  input  logic sck_in,
  input  logic fs_in,
  output logic rise,
  output logic fall,
  output logic fs_s
);
  logic sck_a, sck_b, fs_a;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_a <= 1'b0;
      sck_b <= 1'b0;
      fs_a  <= 1'b0;
    end else begin
      sck_a <= sck_in;
      sck_b <= sck_a;
      fs_a  <= fs_in;
    end
  end

  assign rise = sck_a & ~sck_b;
  assign fall = ~sck_a & sck_b;
  assign fs_s = fs_a;
endmodule

// File: rtl/fsx_framer.sv
// Decides on which rising bit-clock edge a word begins for one direction.
module fsx_framer (
  input  logic clk,
  input  logic rst,
  input  logic rise,
  input  logic fs,
  input  logic bit_mode,
  input  logic gated,
  input  logic cnt_zero,
  input  logic cnt_le1,
  output logic start
);
  logic armed;

  // One-bit style: the sync level seen at a rising edge that closes the
  // current word (or finds the side idle) arms the next rising edge.
  always_ff @(posedge clk) begin
    if (rst) begin
      armed <= 1'b0;
    end else if (rise) begin
      armed <= ~gated & bit_mode & fs & cnt_le1;
    end
  end

  always_comb begin
    if (gated)         start = rise & cnt_zero;
    else if (bit_mode) start = rise & armed & cnt_zero;
    else               start = rise & fs & cnt_zero;
  end
endmodule

// File: rtl/fsx_tx.sv
// Transmit holding register and MSB-first output shifter.
module fsx_tx #(
  parameter int MAX_W = 24,
  parameter int CW    = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rise,
  input  logic             fall,
  input  logic             gated,
  input  logic             start,
  input  logic [CW-1:0]    w,
  input  logic             load,
  input  logic [MAX_W-1:0] load_data,
  output logic             empty,
  output logic             oe,
  output logic             sd,
  output logic             cnt_zero,
  output logic             cnt_le1
);
  logic [MAX_W-1:0] hold, sh, aligned;
  logic [CW-1:0]    cnt;

  assign aligned  = hold << (MAX_W - int'(w));
  assign cnt_zero = (cnt == '0);
  assign cnt_le1  = (cnt <= CW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      hold  <= '0;
      sh    <= '0;
      cnt   <= '0;
      oe    <= 1'b0;
      sd    <= 1'b0;
      empty <= 1'b1;
    end else begin
      if (start) empty <= 1'b1;
      if (load) begin
        hold  <= load_data;
        empty <= 1'b0;
      end
      if (start) begin
        sd  <= aligned[MAX_W-1];
        sh  <= aligned << 1;
        cnt <= w - CW'(1);
        oe  <= 1'b1;
      end else if (rise && !cnt_zero) begin
        sd  <= sh[MAX_W-1];
        sh  <= sh << 1;
        cnt <= cnt - CW'(1);
      end else if (rise && !gated) begin
        oe <= 1'b0;
        sd <= 1'b0;
      end else if (fall && gated && cnt_zero) begin
        oe <= 1'b0;
        sd <= 1'b0;
      end
    end
  end

  assert_oe_follows_start_R2: assert property (@(posedge clk) disable iff (rst)
    start |=> oe);
  assert_oe_drop_edge_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(oe) |-> $past(gated ? fall : rise));
  assert_empty_on_move_R10: assert property (@(posedge clk) disable iff (rst)
    (start && !load) |=> empty);
  assert_quiet_line_R7: assert property (@(posedge clk) disable iff (rst)
    !oe |-> !sd);
endmodule

// File: rtl/fsx_rx.sv
// Receive shifter sampling on falling edges and receive data register.
module fsx_rx #(
  parameter int MAX_W = 24,
  parameter int CW    = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fall,
  input  logic             start,
  input  logic             sd_in,
  input  logic [CW-1:0]    w,
  input  logic             ack,
  output logic [MAX_W-1:0] data,
  output logic             full,
  output logic             cnt_zero,
  output logic             cnt_le1
);
  logic [MAX_W-2:0] sh;
  logic [MAX_W-1:0] shv, mask;
  logic [CW-1:0]    cnt;
  logic             sd_q;
  logic             done;

  assign shv      = {sh, sd_q};
  assign mask     = {MAX_W{1'b1}} >> (MAX_W - int'(w));
  assign cnt_zero = (cnt == '0);
  assign cnt_le1  = (cnt <= CW'(1));
  assign done     = fall && (cnt == CW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      sd_q <= 1'b0;
      sh   <= '0;
      cnt  <= '0;
      data <= '0;
      full <= 1'b0;
    end else begin
      sd_q <= sd_in;
      if (start) begin
        cnt <= w;
      end else if (fall && !cnt_zero) begin
        sh  <= shv[MAX_W-2:0];
        cnt <= cnt - CW'(1);
      end
      if (done) data <= shv & mask;
      if (done)     full <= 1'b1;
      else if (ack) full <= 1'b0;
    end
  end

  assert_full_after_fall_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(full) |-> $past(fall));
  assert_cnt_bound_R1: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(MAX_W));
endmodule

// File: rtl/fsx_xcvr.sv
module fsx_xcvr #(
  parameter int MAX_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       cfg_wl,
  input  logic             cfg_fs_bit,
  input  logic             cfg_fs_diff,
  input  logic             cfg_gated,
  input  logic             cfg_sync,
  input  logic             cfg_single_word,
  input  logic             tx_sck,
  input  logic             tx_fs,
  input  logic             rx_sck,
  input  logic             rx_fs,
  input  logic             rx_sd,
  input  logic [MAX_W-1:0] tx_data,
  input  logic             tx_load,
  input  logic             rx_ack,
  output logic             tx_sd,
  output logic             tx_oe,
  output logic             tx_empty,
  output logic [MAX_W-1:0] rx_data,
  output logic             rx_full,
  output logic             cfg_err
);
  localparam int CW = $clog2(MAX_W + 1);

  logic [CW-1:0] w;
  logic tx_bit, rx_bit;
  logic rx_sck_m, rx_fs_m;
  logic t_rise, t_fall, t_fs, r_rise, r_fall, r_fs;
  logic t_start, r_start;
  logic t_zero, t_le1, r_zero, r_le1;

  assign w        = CW'(fsx_pkg::word_bits(cfg_wl));
  assign rx_bit   = cfg_fs_bit;
  assign tx_bit   = cfg_fs_bit ^ cfg_fs_diff;
  assign rx_sck_m = cfg_sync ? tx_sck : rx_sck;
  assign rx_fs_m  = cfg_sync ? tx_fs  : rx_fs;

  always_ff @(posedge clk) begin
    if (rst) cfg_err <= 1'b0;
    else     cfg_err <= ~cfg_gated & cfg_single_word & (~tx_bit | ~rx_bit);
  end

  fsx_edge u_tedge (.clk(clk), .rst(rst), .sck_in(tx_sck), .fs_in(tx_fs),
                    .rise(t_rise), .fall(t_fall), .fs_s(t_fs));
  fsx_edge u_redge (.clk(clk), .rst(rst), .sck_in(rx_sck_m), .fs_in(rx_fs_m),
                    .rise(r_rise), .fall(r_fall), .fs_s(r_fs));

  fsx_framer u_tfrm (.clk(clk), .rst(rst), .rise(t_rise), .fs(t_fs),
                     .bit_mode(tx_bit), .gated(cfg_gated), .cnt_zero(t_zero),
                     .cnt_le1(t_le1), .start(t_start));
  fsx_framer u_rfrm (.clk(clk), .rst(rst), .rise(r_rise), .fs(r_fs),
                     .bit_mode(rx_bit), .gated(cfg_gated), .cnt_zero(r_zero),
                     .cnt_le1(r_le1), .start(r_start));

  fsx_tx #(.MAX_W(MAX_W), .CW(CW)) u_tx (
    .clk(clk), .rst(rst), .rise(t_rise), .fall(t_fall), .gated(cfg_gated),
    .start(t_start), .w(w), .load(tx_load), .load_data(tx_data),
    .empty(tx_empty), .oe(tx_oe), .sd(tx_sd), .cnt_zero(t_zero), .cnt_le1(t_le1));

  fsx_rx #(.MAX_W(MAX_W), .CW(CW)) u_rx (
    .clk(clk), .rst(rst), .fall(r_fall), .start(r_start), .sd_in(rx_sd),
    .w(w), .ack(rx_ack), .data(rx_data), .full(rx_full),
    .cnt_zero(r_zero), .cnt_le1(r_le1));

  assert_err_tracks_cfg_R12: assert property (@(posedge clk) disable iff (rst)
    (cfg_gated && $stable(cfg_gated)) |=> !cfg_err);
endmodule

// File: tb/tb_fsx_xcvr.sv
module tb_fsx_xcvr;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst;
  logic [1:0] cfg_wl;
  logic cfg_fs_bit, cfg_fs_diff, cfg_gated, cfg_sync, cfg_single_word;
  logic tx_sck, tx_fs, rx_sck, rx_fs, rx_sd;
  logic [23:0] tx_data, rx_data;
  logic tx_load, rx_ack, tx_sd, tx_oe, tx_empty, rx_full, cfg_err;

  fsx_xcvr #(.MAX_W(24)) dut (.*);

  int nchk = 0, nerr = 0;
  logic tck_en, rck_en;
  logic mid_sd, mid_oe, end_sd, end_oe;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [23:0] pat(input int s, input int w);
    logic [31:0] x;
    x = 32'h6B8B4567 ^ (s * 32'h9E3779B1);
    return x[23:0] & (24'hFFFFFF >> (24 - w));
  endfunction

  function automatic int wbits(input int sel);
    return (sel == 3) ? 24 : 8 + 4 * sel;
  endfunction

  // One bit-clock period: rise, 4 cycles high, fall, 5 cycles low.
  task automatic bitp(input logic tfs, input logic rfs, input logic d,
                      input logic ld, input logic [23:0] ldv, input logic ak);
    @(negedge clk); tx_sck = tck_en; rx_sck = rck_en; tx_fs = tfs; rx_fs = rfs; rx_sd = d;
    @(negedge clk); if (ld) begin tx_load = 1'b1; tx_data = ldv; end
    @(negedge clk); tx_load = 1'b0;
    @(negedge clk);
    @(negedge clk); mid_sd = tx_sd; mid_oe = tx_oe; tx_sck = 1'b0; rx_sck = 1'b0;
    @(negedge clk); if (ak) rx_ack = 1'b1;
    @(negedge clk); rx_ack = 1'b0;
    @(negedge clk);
    @(negedge clk); end_sd = tx_sd; end_oe = tx_oe;
  endtask

  task automatic load_word(input logic [23:0] v);
    @(negedge clk); tx_load = 1'b1; tx_data = v;
    @(negedge clk); tx_load = 1'b0;
  endtask

  task automatic ack_pulse();
    @(negedge clk); rx_ack = 1'b1;
    @(negedge clk); rx_ack = 1'b0;
  endtask

  task automatic set_cfg(input int wl, input logic fb, input logic df,
                         input logic g, input logic sy);
    @(negedge clk);
    cfg_wl = 2'(wl); cfg_fs_bit = fb; cfg_fs_diff = df; cfg_gated = g; cfg_sync = sy;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
    $finish;
  end

  initial begin
    logic [23:0] ta, tb2, ra, rb;
    int w;
    rst = 1'b1; cfg_wl = 0; cfg_fs_bit = 0; cfg_fs_diff = 0; cfg_gated = 0;
    cfg_sync = 1; cfg_single_word = 0; tx_sck = 0; tx_fs = 0; rx_sck = 0;
    rx_fs = 0; rx_sd = 0; tx_data = 0; tx_load = 0; rx_ack = 0;
    tck_en = 1; rck_en = 0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // Reset state
    check("reset tx_oe R7", 32'(tx_oe), 0);
    check("reset tx_sd R7", 32'(tx_sd), 0);
    check("reset tx_empty R10", 32'(tx_empty), 1);
    check("reset rx_full R5", 32'(rx_full), 0);
    check("reset rx_data R5", 32'(rx_data), 0);
    check("reset cfg_err R12", 32'(cfg_err), 0);

    // Sweep all word lengths in both framing styles, shared clock (R1 R2 R3 R5 R9)
    for (int wl = 0; wl < 4; wl++) begin
      for (int bm = 0; bm < 2; bm++) begin
        w = wbits(wl);
        set_cfg(wl, bm[0], 1'b0, 1'b0, 1'b1);
        tck_en = 1; rck_en = 0;
        ta = pat(wl * 2 + bm, w); ra = pat(wl * 2 + bm + 40, w);
        ack_pulse();
        load_word(ta);
        check("load clears empty R10", 32'(tx_empty), 0);
        if (bm == 1) begin
          bitp(1'b1, 1'b0, 1'b0, 1'b0, 24'h0, 1'b0);
          check("sync bit quiet R3", 32'(end_oe), 0);
        end
        for (int k = 0; k < w; k++) begin
          bitp(bm == 0, bm == 1, ra[w-1-k], 1'b0, 24'h0, 1'b0);
          check(bm ? "tx bit R3" : "tx bit R2", 32'(mid_sd), 32'(ta[w-1-k]));
          check("oe during word R7", 32'(mid_oe), 1);
          if (k == 0) check("empty after move R10", 32'(tx_empty), 1);
        end
        check("oe holds through last bit R7", 32'(end_oe), 1);
        check("rx full R5", 32'(rx_full), 1);
        check("rx word R1 R5 R9", 32'(rx_data), 32'(ra));
        bitp(1'b0, 1'b1, 1'b0, 1'b0, 24'h0, 1'b0);
        check("oe drops idle R7", 32'(end_oe), 0);
        check("sd zero idle R7", 32'(end_sd), 0);
      end
    end

    // Back-to-back words in both styles (R13)
    for (int bm = 0; bm < 2; bm++) begin
      w = (bm == 0) ? 12 : 8;
      set_cfg(bm == 0 ? 1 : 0, bm[0], 1'b0, 1'b0, 1'b1);
      ta = pat(70 + bm, w); tb2 = pat(80 + bm, w);
      ra = pat(90 + bm, w); rb = pat(100 + bm, w);
      ack_pulse();
      load_word(ta);
      if (bm == 1) bitp(1'b1, 1'b0, 1'b0, 1'b0, 24'h0, 1'b0);
      for (int k = 0; k < 2 * w; k++) begin
        bitp(bm == 0 ? 1'b1 : (k == w - 1), 1'b0,
             k < w ? ra[w-1-k] : rb[2*w-1-k], 1'b0, 24'h0, 1'b0);
        if (k == 1) load_word(tb2);
        check("b2b bit R13", 32'(mid_sd), k < w ? 32'(ta[w-1-k]) : 32'(tb2[2*w-1-k]));
        check("b2b oe R13", 32'(mid_oe), 1);
        if (k == w - 1) check("b2b first rx R13", 32'(rx_data), 32'(ra));
      end
      check("b2b second rx R13", 32'(rx_data), 32'(rb));
      bitp(1'b0, 1'b0, 1'b0, 1'b0, 24'h0, 1'b0);
      check("b2b end oe R13", 32'(end_oe), 0);
    end

    // Mid-word sync pulse ignored, one-bit style, 8 bits (R6)
    set_cfg(0, 1'b1, 1'b0, 1'b0, 1'b1);
    ta = pat(110, 8);
    load_word(ta);
    bitp(1'b1, 1'b0, 1'b0, 1'b0, 24'h0, 1'b0);
    for (int k = 0; k < 8; k++) begin
      bitp(k == 2, 1'b0, 1'b0, 1'b0, 24'h0, 1'b0);
      check("mid-word sync ignored bit R6", 32'(mid_sd), 32'(ta[7-k]));
    end
    bitp(1'b0, 1'b0, 1'b0, 1'b0, 24'h0, 1'b0);
    check("no restart after stray sync R6", 32'(end_oe), 0);

    // Load coinciding with move; ack coinciding with completion (R10 R11)
    set_cfg(0, 1'b0, 1'b0, 1'b0, 1'b1);
    ta = pat(120, 8); tb2 = pat(121, 8); ra = pat(122, 8);
    ack_pulse();
    load_word(ta);
    for (int k = 0; k < 16; k++) begin
      bitp(1'b1, 1'b0, k < 8 ? ra[7-k] : 1'b0, k == 0, tb2, k == 7);
      check("collision bit R10", 32'(mid_sd), k < 8 ? 32'(ta[7-k]) : 32'(tb2[15-k]));
      if (k == 0) check("load wins over move R10", 32'(tx_empty), 0);
      if (k == 7) check("completion wins over ack R11", 32'(rx_full), 1);
      if (k == 8) check("second move empties R10", 32'(tx_empty), 1);
    end
    bitp(1'b0, 1'b0, 1'b0, 1'b0, 24'h0, 1'b0);
    ack_pulse();
    check("ack clears full R11", 32'(rx_full), 0);

    // Gated clock: bursts frame the words (R8)
    set_cfg(0, 1'b0, 1'b0, 1'b1, 1'b1);
    for (int b = 0; b < 2; b++) begin
      ta = pat(130 + b, 8); ra = pat(140 + b, 8);
      ack_pulse();
      load_word(ta);
      for (int k = 0; k < 8; k++) begin
        bitp(1'b0, 1'b0, ra[7-k], 1'b0, 24'h0, 1'b0);
        check("gated bit R8", 32'(mid_sd), 32'(ta[7-k]));
        check("gated oe mid R8", 32'(mid_oe), 1);
        check("gated oe end R8", 32'(end_oe), k < 7 ? 1 : 0);
      end
      check("gated rx word R8", 32'(rx_data), 32'(ra));
    end

    // Separate receive clock and sync; transmit clock idle (R9)
    set_cfg(2, 1'b0, 1'b0, 1'b0, 1'b0);
    tck_en = 0; rck_en = 1;
    ra = pat(150, 16);
    ack_pulse();
    for (int k = 0; k < 16; k++) begin
      bitp(1'b0, 1'b1, ra[15-k], 1'b0, 24'h0, 1'b0);
      check("tx silent without its clock R9", 32'(mid_oe), 0);
    end
    check("separate rx word R9", 32'(rx_data), 32'(ra));

    // Mixed framing styles per direction (R4)
    tck_en = 1; rck_en = 1;
    for (int fb = 0; fb < 2; fb++) begin
      set_cfg(0, fb[0], 1'b1, 1'b0, 1'b0);
      ta = pat(160 + fb, 8); ra = pat(170 + fb, 8);
      ack_pulse();
      load_word(ta);
      // tx one-bit when fb=0, rx one-bit when fb=1
      bitp(fb == 0, fb == 1, 1'b0, 1'b0, 24'h0, 1'b0);
      check("mixed sync bit quiet R4", 32'(end_oe), 0);
      for (int k = 0; k < 8; k++) begin
        bitp(fb == 1, fb == 0, ra[7-k], 1'b0, 24'h0, 1'b0);
        check("mixed tx bit R4", 32'(mid_sd), 32'(ta[7-k]));
      end
      check("mixed rx word R4", 32'(rx_data), 32'(ra));
      bitp(1'b0, 1'b0, 1'b0, 1'b0, 24'h0, 1'b0);
    end

    // Unsupported-combination flag over all relevant settings (R12)
    for (int c = 0; c < 16; c++) begin
      @(negedge clk);
      cfg_gated = c[0]; cfg_single_word = c[1]; cfg_fs_bit = c[2]; cfg_fs_diff = c[3];
      @(negedge clk); @(negedge clk);
      check("cfg_err R12", 32'(cfg_err),
            32'(!c[0] && c[1] && (!c[2] || !(c[2] ^ c[3]))));
    end
    cfg_single_word = 0;

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
    $finish;
  end
endmodule